// File: doc/BRIEF.md
# GPIO Direction and Pull-up Controller

This block holds the per-pin direction state and output data for a bank of byte-wide general-purpose I/O ports, and produces the pad-level controls for each pin: driver enable, output value and weak pull-up enable. A core writes a direction byte by presenting an accumulator value, a port address and a one-cycle direction write strobe. It reads a direction byte back through a registered read mux that answers one cycle after a read strobe. Output data bytes are loaded through a separate strobe that selects a port by index. Incoming pad values pass through a two-flop synchroniser before the core sees them.

A direction bit of 1 puts its pin in input mode and turns its driver off. A bit of 0 drives the pin from the output latch. Weak pull-ups exist only on pins chosen at build time by a mask parameter. Such a pull-up turns on when the pin is in input mode and either the shared active-low pull-up control or that port's own active-low control is low. All strobes are plain single-cycle controls with no back-pressure: the block accepts a request in every cycle, and each read returns its byte in the cycle after its strobe with `dir_rvalid` high for exactly that cycle. No ready signal exists, so the core has no way to stall a read response.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, every direction bit is 1, every output latch bit is 0, `pad_oe`, `pad_out`, `pin_sync`, `dir_rdata` and `dir_rvalid` are all 0, and `pad_pu` is 0 while both pull-up controls are high.
- R2: A `dir_we` strobe with `dir_addr` equal to 05h + p (p = 0 for port A up to p = 4 for port E) loads `acc_in` into the direction register of port p. The new value shows on the pad controls after the next rising clock edge.
- R3: A `dir_re` strobe at a port address sets `dir_rvalid` high in the next cycle only, with `dir_rdata` holding that port's direction byte. `dir_rdata` keeps its value while no read is made.
- R4: A `dir_we` strobe at an address outside 05h–09h changes no register. A `dir_re` at such an address returns `dir_rdata` = 00h, and `dir_rvalid` is still high in the next cycle.
- R5: Pin b of port p occupies bit 8p+b of every flat pin bus. `pad_oe` at that bit is the inverse of direction bit b of port p. `pad_out` at that bit is bit b of port p's output latch.
- R6: An `out_we` strobe with `out_port` in 0–4 loads `acc_in` into that port's output latch, effective after the next rising edge. With `out_port` in 5–7 the strobe changes nothing.
- R7: `pad_pu` at a pin is 1 only if the pin's bit is set in `PU_MASK`, its direction bit is 1, and `pu_all_n` or `pu_port_n[p]` is 0. The default mask selects all of port B, bits 4–5 of port C and bits 0–5 of port E. The output follows the control inputs in the same cycle.
- R8: `pad_pu` is 0 on every pin whose driver is enabled, whatever the pull-up controls are.
- R9: `pin_sync` equals `pad_in` as sampled two rising edges earlier.
- R10: When `dir_we` and `dir_re` target the same address in one cycle, the read returns the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 8 | Accumulator value for direction and latch writes |
| dir_we | input | 1 | Direction write strobe |
| dir_re | input | 1 | Direction read strobe |
| dir_addr | input | 8 | Direction register address (05h–09h valid) |
| dir_rdata | output | 8 | Direction read data |
| dir_rvalid | output | 1 | High for the cycle after a read strobe |
| out_we | input | 1 | Output latch write strobe |
| out_port | input | 3 | Output latch port index (0–4 valid) |
| pu_all_n | input | 1 | Shared pull-up control, active low |
| pu_port_n | input | 5 | Per-port pull-up controls, active low |
| pad_in | input | 40 | Raw pad input values |
| pin_sync | output | 40 | Synchronised pad input values |
| pad_oe | output | 40 | Pad driver enables |
| pad_out | output | 40 | Pad output values |
| pad_pu | output | 40 | Pad pull-up enables |

## Verification
The assertions assume that the strobes and addresses are stable, known values at every rising edge once reset is released. They also assume that `dir_we` and `out_we` are the only inputs that change stored state. The bench keeps to this by changing every input only on the falling clock edge. It holds all inputs at idle values while reset is low, and it never leaves an input undriven. Pull-up controls and pad inputs are changed only between strobes, so each check can be traced to a single cause.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;
  localparam int DEF_NPORTS = 5;
  localparam int DEF_PW     = 8;
  localparam int DEF_AW     = 8;
  localparam int DEF_BASE   = 5;

  // Default pull-up population: port B all, port C bits 4-5, port E bits 0-5
  localparam logic [DEF_NPORTS*DEF_PW-1:0] DEF_PU_MASK = 40'h3F_00_30_FF_00;

  typedef enum logic [1:0] {
    SYNC_S0 = 2'd0,
    SYNC_S1 = 2'd1,
    SYNC_OK = 2'd2
  } sync_age_e;
endpackage

// File: rtl/gpio_dir_bank.sv
module gpio_dir_bank #(
  parameter int NPORTS = 5,
  parameter int PW     = 8,
  parameter int AW     = 8,
  parameter int BASE   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 re,
  input  logic [AW-1:0]        addr,
  input  logic [PW-1:0]        wdata,
  output logic [NPORTS*PW-1:0] dir_q,
  output logic [PW-1:0]        rdata,
  output logic                 rvalid
);
  logic [NPORTS-1:0] hit;
  logic [PW-1:0]     rd_sel;

  for (genvar p = 0; p < NPORTS; p++) begin : g_reg
    localparam logic [AW-1:0] PADDR = AW'(BASE + p);
    assign hit[p] = (addr == PADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dir_q[p*PW +: PW] <= '1;
      else if (we && hit[p])
        dir_q[p*PW +: PW] <= wdata;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NPORTS; p++)
      if (hit[p]) rd_sel = dir_q[p*PW +: PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_sel;
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NPORTS = 5,
  parameter int PW     = 8,
  parameter int IW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        sel,
  input  logic [PW-1:0]        wdata,
  output logic [NPORTS*PW-1:0] lat_q
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_lat
    localparam logic [IW-1:0] PIDX = IW'(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lat_q[p*PW +: PW] <= '0;
      else if (we && sel == PIDX)
        lat_q[p*PW +: PW] <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int          PW   = 8,
  parameter logic [PW-1:0] MASK = '1
) (
  input  logic [PW-1:0] dir,
  input  logic [PW-1:0] lat,
  input  logic          pu_all_n,
  input  logic          pu_own_n,
  output logic [PW-1:0] oe,
  output logic [PW-1:0] dout,
  output logic [PW-1:0] pu
);
  logic pu_req;

  // Either active-low control at zero requests the pull-ups
  assign pu_req = ~(pu_all_n & pu_own_n);
  assign oe     = ~dir;
  assign dout   = lat;

  for (genvar b = 0; b < PW; b++) begin : g_pin
    if (MASK[b]) begin : g_has_pu
      assign pu[b] = pu_req & dir[b];
    end else begin : g_no_pu
      assign pu[b] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_dir_pkg::*;
#(
  parameter int NPORTS = DEF_NPORTS,
  parameter int PW     = DEF_PW,
  parameter int AW     = DEF_AW,
  parameter int BASE   = DEF_BASE,
  parameter logic [NPORTS*PW-1:0] PU_MASK = DEF_PU_MASK,
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int NB = NPORTS * PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     acc_in,
  input  logic              dir_we,
  input  logic              dir_re,
  input  logic [AW-1:0]     dir_addr,
  output logic [PW-1:0]     dir_rdata,
  output logic              dir_rvalid,
  input  logic              out_we,
  input  logic [IW-1:0]     out_port,
  input  logic              pu_all_n,
  input  logic [NPORTS-1:0] pu_port_n,
  input  logic [NB-1:0]     pad_in,
  output logic [NB-1:0]     pin_sync,
  output logic [NB-1:0]     pad_oe,
  output logic [NB-1:0]     pad_out,
  output logic [NB-1:0]     pad_pu
);
  logic [NB-1:0] dir_q;
  logic [NB-1:0] lat_q;

  gpio_dir_bank #(.NPORTS(NPORTS), .PW(PW), .AW(AW), .BASE(BASE)) u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dir_we),
    .re    (dir_re),
    .addr  (dir_addr),
    .wdata (acc_in),
    .dir_q (dir_q),
    .rdata (dir_rdata),
    .rvalid(dir_rvalid)
  );

  gpio_out_latch #(.NPORTS(NPORTS), .PW(PW), .IW(IW)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (out_we),
    .sel   (out_port),
    .wdata (acc_in),
    .lat_q (lat_q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpio_pad_ctrl #(.PW(PW), .MASK(PU_MASK[p*PW +: PW])) u_pad (
      .dir     (dir_q[p*PW +: PW]),
      .lat     (lat_q[p*PW +: PW]),
      .pu_all_n(pu_all_n),
      .pu_own_n(pu_port_n[p]),
      .oe      (pad_oe[p*PW +: PW]),
      .dout    (pad_out[p*PW +: PW]),
      .pu      (pad_pu[p*PW +: PW])
    );
  end

  gpio_in_sync #(.W(NB)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pin_sync)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPORTS = 5,
  parameter int PW     = 8,
  parameter int AW     = 8,
  parameter int BASE   = 5,
  parameter int IW     = 3,
  parameter logic [NPORTS*PW-1:0] PU_MASK = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        acc_in,
  input logic                 dir_we,
  input logic                 dir_re,
  input logic [AW-1:0]        dir_addr,
  input logic [PW-1:0]        dir_rdata,
  input logic                 dir_rvalid,
  input logic                 out_we,
  input logic [IW-1:0]        out_port,
  input logic [NPORTS*PW-1:0] pad_in,
  input logic [NPORTS*PW-1:0] pin_sync,
  input logic [NPORTS*PW-1:0] pad_oe,
  input logic [NPORTS*PW-1:0] pad_out,
  input logic [NPORTS*PW-1:0] pad_pu
);
  localparam int unsigned LO = BASE;
  localparam int unsigned HI = BASE + NPORTS;

  logic addr_miss;
  logic [1:0] age;

  assign addr_miss = (32'(dir_addr) < LO) || (32'(dir_addr) >= HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    localparam logic [AW-1:0] PADDR = AW'(BASE + p);
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_we && dir_addr == PADDR) |=> pad_oe[p*PW +: PW] == ~$past(acc_in))
      else $error("R2 direction write not reflected on port %0d", p);
  end

  a_r3_rvalid_set: assert property (@(posedge clk) disable iff (!rst_n)
    dir_re |=> dir_rvalid) else $error("R3 rvalid missing");
  a_r3_rvalid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_re |=> !dir_rvalid) else $error("R3 rvalid spurious");
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_re |=> $stable(dir_rdata)) else $error("R3 rdata changed without read");
  a_r4_miss_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_re && addr_miss) |=> dir_rdata == '0) else $error("R4 miss read nonzero");
  a_r4_miss_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && addr_miss) |=> $stable(pad_oe)) else $error("R4 miss write changed state");
  a_r6_bad_port_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && 32'(out_port) >= NPORTS) |=> $stable(pad_out)) else $error("R6 bad index wrote");
  a_r7_pu_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~PU_MASK) == '0) else $error("R7 pull-up on unmasked pin");
  a_r8_pu_off_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0) else $error("R8 pull-up on driven pin");
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> pin_sync == $past(pad_in, 2)) else $error("R9 sync delay wrong");
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NPORTS(NPORTS), .PW(PW), .AW(AW), .BASE(BASE), .IW(IW), .PU_MASK(PU_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .dir_we(dir_we), .dir_re(dir_re),
  .dir_addr(dir_addr), .dir_rdata(dir_rdata), .dir_rvalid(dir_rvalid),
  .out_we(out_we), .out_port(out_port), .pad_in(pad_in), .pin_sync(pin_sync),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  acc_in = '0;
  logic        dir_we = 1'b0, dir_re = 1'b0, out_we = 1'b0;
  logic [7:0]  dir_addr = '0;
  logic [2:0]  out_port = '0;
  logic        pu_all_n = 1'b1;
  logic [4:0]  pu_port_n = 5'h1F;
  logic [39:0] pad_in = '0;
  logic [7:0]  dir_rdata;
  logic        dir_rvalid;
  logic [39:0] pin_sync, pad_oe, pad_out, pad_pu;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .dir_we(dir_we), .dir_re(dir_re),
    .dir_addr(dir_addr), .dir_rdata(dir_rdata), .dir_rvalid(dir_rvalid),
    .out_we(out_we), .out_port(out_port), .pu_all_n(pu_all_n), .pu_port_n(pu_port_n),
    .pad_in(pad_in), .pin_sync(pin_sync), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dir_we = 0; dir_re = 0; out_we = 0; acc_in = '0;
    dir_addr = '0; out_port = '0; pu_all_n = 1; pu_port_n = 5'h1F; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic dir_write(input logic [7:0] a, input logic [7:0] v);
    dir_addr = a; acc_in = v; dir_we = 1'b1;
    @(negedge clk);
    dir_we = 1'b0;
  endtask

  task automatic dir_read(input logic [7:0] a, output logic [7:0] v, output logic vld);
    dir_addr = a; dir_re = 1'b1;
    @(negedge clk);
    dir_re = 1'b0;
    v = dir_rdata; vld = dir_rvalid;
  endtask

  task automatic lat_write(input logic [2:0] idx, input logic [7:0] v);
    out_port = idx; acc_in = v; out_we = 1'b1;
    @(negedge clk);
    out_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_out", 64'(pad_out), 64'h0);
    chk("R1 pad_pu", 64'(pad_pu), 64'h0);
    chk("R1 pin_sync", 64'(pin_sync), 64'h0);
    chk("R1 rvalid", 64'(dir_rvalid), 64'h0);
    chk("R1 rdata", 64'(dir_rdata), 64'h0);
  endtask

  task automatic t_dir_rw();
    logic [7:0] v; logic vld;
    do_reset();
    dir_write(8'h05, 8'h00);
    chk("R2 port A output", 64'(pad_oe), 64'h00_00_00_00_FF);
    dir_write(8'h07, 8'hA5);
    dir_write(8'h09, 8'h3C);
    chk("R2 R5 pad_oe", 64'(pad_oe), 64'hC3_00_5A_00_FF);
    dir_read(8'h07, v, vld);
    chk("R3 read C", 64'(v), 64'hA5);
    chk("R3 rvalid", 64'(vld), 64'h1);
    @(negedge clk);
    chk("R3 rvalid single", 64'(dir_rvalid), 64'h0);
    chk("R3 rdata held", 64'(dir_rdata), 64'hA5);
    dir_read(8'h09, v, vld);
    chk("R3 read E", 64'(v), 64'h3C);
    dir_read(8'h06, v, vld);
    chk("R1 R3 read B reset ones", 64'(v), 64'hFF);
  endtask

  task automatic t_bad_addr();
    logic [7:0] v; logic vld;
    do_reset();
    dir_write(8'h07, 8'h11);
    dir_write(8'h04, 8'h00);
    dir_write(8'h0A, 8'h00);
    dir_write(8'hFF, 8'h00);
    chk("R4 miss writes ignored", 64'(pad_oe), 64'h00_00_EE_00_00);
    dir_read(8'h07, v, vld);
    chk("R4 port C intact", 64'(v), 64'h11);
    dir_read(8'h04, v, vld);
    chk("R4 read 04h zero", 64'(v), 64'h0);
    chk("R4 read 04h valid", 64'(vld), 64'h1);
    dir_read(8'h07, v, vld);
    dir_read(8'h0A, v, vld);
    chk("R4 read 0Ah zero", 64'(v), 64'h0);
  endtask

  task automatic t_latch();
    do_reset();
    lat_write(3'd2, 8'h5A);
    lat_write(3'd0, 8'h81);
    chk("R6 latch write", 64'(pad_out), 64'h00_00_5A_00_81);
    lat_write(3'd5, 8'hFF);
    lat_write(3'd7, 8'hFF);
    chk("R6 bad index ignored", 64'(pad_out), 64'h00_00_5A_00_81);
    chk("R5 latch leaves oe", 64'(pad_oe), 64'h0);
  endtask

  task automatic t_pullup();
    do_reset();
    #1 chk("R7 both high off", 64'(pad_pu), 64'h0);
    pu_all_n = 1'b0;
    #1 chk("R7 shared low", 64'(pad_pu), 64'h3F_00_30_FF_00);
    pu_all_n = 1'b1; pu_port_n = 5'b11101;
    #1 chk("R7 port B low", 64'(pad_pu), 64'h00_00_00_FF_00);
    pu_port_n = 5'b01111;
    #1 chk("R7 port E low", 64'(pad_pu), 64'h3F_00_00_00_00);
    pu_port_n = 5'b11110;
    #1 chk("R7 port A unmasked", 64'(pad_pu), 64'h0);
    pu_port_n = 5'h1F;
    @(negedge clk);
  endtask

  task automatic t_pu_forced();
    do_reset();
    pu_all_n = 1'b0;
    dir_write(8'h06, 8'h0F);
    dir_write(8'h07, 8'h10);
    chk("R8 driven pins no pull-up", 64'(pad_pu), 64'h3F_00_10_0F_00);
    dir_write(8'h09, 8'h00);
    chk("R8 port E driven", 64'(pad_pu), 64'h00_00_10_0F_00);
  endtask

  task automatic t_sync();
    do_reset();
    pad_in = 40'h12_34_56_78_9A;
    @(negedge clk);
    chk("R9 one edge not yet", 64'(pin_sync), 64'h0);
    pad_in = 40'hFF_00_FF_00_FF;
    @(negedge clk);
    chk("R9 two edges", 64'(pin_sync), 64'h12_34_56_78_9A);
    @(negedge clk);
    chk("R9 next value", 64'(pin_sync), 64'hFF_00_FF_00_FF);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v; logic vld;
    do_reset();
    dir_addr = 8'h08; acc_in = 8'h77; dir_we = 1'b1; dir_re = 1'b1;
    @(negedge clk);
    dir_we = 1'b0; dir_re = 1'b0;
    chk("R10 old value", 64'(dir_rdata), 64'hFF);
    dir_read(8'h08, v, vld);
    chk("R10 new value after", 64'(v), 64'h77);
  endtask

  initial begin
    t_reset();
    t_dir_rw();
    t_bad_addr();
    t_latch();
    t_pullup();
    t_pu_forced();
    t_sync();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule